// File: doc/BRIEF.md
# GPIO Pin-Configuration Write Guard

This block holds the pin-configuration state of one GPIO port and protects its most sensitive part. The protection has two stages. A lock register accepts a 32-bit magic key. While the key is in place, a commit mask may be rewritten. The commit mask then decides, bit by bit, which pins may have their alternate-function select changed by software. A stray write therefore cannot reassign a pin to a peripheral function.

Besides the guarded registers, the block holds seven plain 8-bit pad-control storage registers and a read-only identification window. A simple synchronous register port (read strobe, write strobe, byte offset, 32-bit write data) reaches all of them. Read data and an error flag appear one cycle after the access. An access to an offset that holds no register is flagged; a write to the identification window and a misaligned access are flagged as well.

Top module: `gpio_cfg_guard`

## Requirements
- R1: A write to offset 0x520 unlocks the block when the whole 32-bit write word equals 0x0ACCE551 and locks it for any other value. No other access changes the lock state.
- R2: A read of offset 0x520 returns 1 while locked and 0 while unlocked, in bit 0 with all other bits zero.
- R3: After reset the block is locked, the commit mask (offset 0x524) reads 0xFF and the alternate-function select (offset 0x420) reads 0x00.
- R4: A write to offset 0x524 stores the low 8 bits of the write word into the commit mask only while unlocked; while locked it leaves the mask unchanged.
- R5: A write to offset 0x420 changes exactly those alternate-function bits whose commit-mask bit is 1, taking them from the low 8 write bits. No other access changes this register, and its value drives the altfn_sel output.
- R6: Offsets 0x500, 0x504, 0x508, 0x50C, 0x518, 0x51C and 0x528 are 8-bit read/write storage that keeps the low 8 bits of a write. The one at 0x500 resets to 0xFF and the others reset to 0x00.
- R7: Reads of offsets 0xFD0 to 0xFFC (word steps) return, in bits 7:0, the bytes 00, 00, 00, 00, 61, 00, 18, 01, 0D, F0, 05, B1 in ascending offset order.
- R8: A read of an unmapped offset returns 0. A write to an unmapped offset or to the identification window changes no register. Any access with a nonzero offset bits 1:0 counts as unmapped.
- R9: err pulses high for exactly the one cycle after each access that R8 describes, and stays low after every other access and on idle cycles.
- R10: rdata and err are registered and are valid in the cycle after the read strobe. rdata holds its value until the next read, and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe, one access per cycle |
| wr_en | input | 1 | Write strobe, one access per cycle |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data word |
| rdata | output | 32 | Registered read data |
| err | output | 1 | One-cycle flag for an unmapped, misaligned or read-only access |
| altfn_sel | output | PORT_W | Current alternate-function select per pin |

## Verification
The assertions assume that rd_en and wr_en are never high in the same cycle. They also assume that the register offsets fit the default 12-bit address window. The bench keeps within both: every access is issued by a single read or write task, which raises exactly one strobe for one cycle. The assertions check the lock transition against the key, the freeze of the commit mask while locked, and the per-bit mask on function-select writes. The bench checks the values that can be read back through the port, including the case where a key matches in its low bits but differs in its upper bits.

// File: rtl/gpio_cfg_guard.sv
module gpio_cfg_guard #(
  parameter int ADDR_W = 12,
  parameter int PORT_W = 8,
  parameter logic [31:0] KEY = 32'h0ACCE551,
  parameter logic [PORT_W-1:0] PAD0_RST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              err,
  output logic [PORT_W-1:0] altfn_sel
);
  localparam int WA = ADDR_W - 2;
  localparam int NPAD = 7;
  localparam logic [11:0] PAD_OFS [NPAD] =
    '{12'h500, 12'h504, 12'h508, 12'h50C, 12'h518, 12'h51C, 12'h528};

  logic [WA-1:0] word;
  logic aligned, alt_hit, lock_hit, cmt_hit, id_hit, mapped, access;
  logic [NPAD-1:0] pad_hit;
  logic [3:0] id_idx;

  logic lock_q;
  logic [PORT_W-1:0] commit_q, altfn_q;
  logic [PORT_W-1:0] pad_q [NPAD];
  logic [31:0] rd_mux;

  assign word     = addr[ADDR_W-1:2];
  assign aligned  = (addr[1:0] == 2'b00);
  assign access   = rd_en | wr_en;
  assign alt_hit  = aligned && word == WA'(12'h420 >> 2);
  assign lock_hit = aligned && word == WA'(12'h520 >> 2);
  assign cmt_hit  = aligned && word == WA'(12'h524 >> 2);
  assign id_idx   = addr[5:2] - 4'd4;
  assign id_hit   = aligned && (&addr[ADDR_W-1:6]) && addr[5:2] >= 4'd4;

  for (genvar g = 0; g < NPAD; g++) begin : g_pad_dec
    assign pad_hit[g] = aligned && word == WA'(PAD_OFS[g] >> 2);
  end

  assign mapped = alt_hit | lock_hit | cmt_hit | id_hit | (|pad_hit);

  function automatic logic [7:0] id_byte(input logic [3:0] i);
    case (i)
      4'd4:  id_byte = 8'h61;
      4'd6:  id_byte = 8'h18;
      4'd7:  id_byte = 8'h01;
      4'd8:  id_byte = 8'h0D;
      4'd9:  id_byte = 8'hF0;
      4'd10: id_byte = 8'h05;
      4'd11: id_byte = 8'hB1;
      default: id_byte = 8'h00;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_q   <= 1'b1;
      commit_q <= '1;
      altfn_q  <= '0;
    end else if (wr_en) begin
      if (lock_hit) lock_q <= (wdata != KEY);
      if (cmt_hit && !lock_q) commit_q <= wdata[PORT_W-1:0];
      if (alt_hit) altfn_q <= (altfn_q & ~commit_q) | (wdata[PORT_W-1:0] & commit_q);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NPAD; i++) begin
      if (!rst_n) pad_q[i] <= (i == 0) ? PAD0_RST : '0;
      else if (wr_en && pad_hit[i]) pad_q[i] <= wdata[PORT_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (lock_hit) rd_mux = {31'd0, lock_q};
    if (cmt_hit)  rd_mux = 32'(commit_q);
    if (alt_hit)  rd_mux = 32'(altfn_q);
    if (id_hit)   rd_mux = {24'd0, id_byte(id_idx)};
    for (int i = 0; i < NPAD; i++)
      if (pad_hit[i]) rd_mux = 32'(pad_q[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      err   <= 1'b0;
    end else begin
      if (rd_en) rdata <= rd_mux;
      err <= (access && !mapped) || (wr_en && id_hit);
    end
  end

  assign altfn_sel = altfn_q;
endmodule

module gpio_cfg_guard_chk #(
  parameter int ADDR_W = 12,
  parameter int PORT_W = 8,
  parameter logic [31:0] KEY = 32'h0ACCE551
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic              err,
  input logic              lock_q,
  input logic [PORT_W-1:0] commit_q,
  input logic [PORT_W-1:0] altfn_q
);
  logic wr_lock, wr_cmt, wr_alt;
  assign wr_lock = wr_en && addr == ADDR_W'(12'h520);
  assign wr_cmt  = wr_en && addr == ADDR_W'(12'h524);
  assign wr_alt  = wr_en && addr == ADDR_W'(12'h420);

  p_lock_key_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lock |=> lock_q == ($past(wdata) != KEY));
  p_lock_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lock |=> $stable(lock_q));
  p_commit_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmt && lock_q) |=> $stable(commit_q));
  p_altfn_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_alt |=> ((altfn_q ^ $past(altfn_q)) & ~$past(commit_q)) == '0);
  p_altfn_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_alt |=> $stable(altfn_q));
  p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(rd_en || wr_en));
  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en));
endmodule

bind gpio_cfg_guard gpio_cfg_guard_chk #(.ADDR_W(ADDR_W), .PORT_W(PORT_W), .KEY(KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .err(err), .lock_q(lock_q), .commit_q(commit_q), .altfn_q(altfn_q)
);

// File: tb/tb_gpio_cfg_guard.sv
`timescale 1ns/1ps
module tb_gpio_cfg_guard;
  logic clk = 1'b0, rst_n = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic err;
  logic [7:0] altfn_sel;

  gpio_cfg_guard dut (.clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .err(err), .altfn_sel(altfn_sel));

  always #5 clk = ~clk;

  typedef struct {
    logic        chk_data;
    logic [31:0] data;
    logic        err;
    string       req;
  } item_t;

  item_t sb[$];
  int n_chk = 0, n_bad = 0;
  logic pend = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  always @(posedge clk) pend <= rd_en | wr_en;

  always @(negedge clk) begin
    if (pend) begin
      if (sb.size() == 0) check("scoreboard-empty", 32'd1, 32'd0);
      else begin
        item_t it;
        it = sb.pop_front();
        if (it.chk_data) check(it.req, rdata, it.data);
        check({it.req, " err"}, {31'd0, err}, {31'd0, it.err});
      end
    end
  end

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input logic e, input string req);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    sb.push_back('{1'b1, exp, e, req});
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic e, input string req);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    sb.push_back('{1'b0, 32'd0, e, req});
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] id_tab [12];
    logic [11:0] pads [7];
    id_tab = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h61, 8'h00, 8'h18, 8'h01, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    pads = '{12'h500, 12'h504, 12'h508, 12'h50C, 12'h518, 12'h51C, 12'h528};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 rdata after reset", rdata, 32'd0);
    check("R9 err after reset", {31'd0, err}, 32'd0);

    rd(12'h520, 32'd1, 1'b0, "R3 R2 locked at reset");
    rd(12'h524, 32'hFF, 1'b0, "R3 commit reset");
    rd(12'h420, 32'h00, 1'b0, "R3 altfn reset");
    rd(12'h500, 32'hFF, 1'b0, "R6 pad0 reset");
    rd(12'h504, 32'h00, 1'b0, "R6 pad1 reset");

    wr(12'h420, 32'hFFFF_FFA5, 1'b0, "R5 write full mask");
    rd(12'h420, 32'hA5, 1'b0, "R5 full mask result");
    check("R5 altfn_sel port", {24'd0, altfn_sel}, 32'hA5);

    wr(12'h524, 32'h0F, 1'b0, "R4 commit write locked");
    rd(12'h524, 32'hFF, 1'b0, "R4 commit unchanged while locked");

    wr(12'h520, 32'h0ACCE551, 1'b0, "R1 key");
    rd(12'h520, 32'd0, 1'b0, "R1 R2 unlocked");
    wr(12'h524, 32'h1234_560F, 1'b0, "R4 commit write unlocked");
    rd(12'h524, 32'h0F, 1'b0, "R4 commit low byte taken");

    wr(12'h420, 32'h3C, 1'b0, "R5 partial mask");
    rd(12'h420, 32'hAC, 1'b0, "R5 only committed bits change");
    wr(12'h524, 32'h00, 1'b0, "R4 clear commit");
    wr(12'h420, 32'hFF, 1'b0, "R5 zero mask");
    rd(12'h420, 32'hAC, 1'b0, "R5 zero mask keeps value");

    wr(12'h520, 32'h0ACCE550, 1'b0, "R1 wrong key");
    rd(12'h520, 32'd1, 1'b0, "R1 wrong key locks");
    wr(12'h520, 32'h0ACCE551, 1'b0, "R1 key again");
    wr(12'h520, 32'h1ACCE551, 1'b0, "R1 upper bits differ");
    rd(12'h520, 32'd1, 1'b0, "R1 full 32-bit compare");
    wr(12'h524, 32'hF0, 1'b0, "R4 relocked write");
    rd(12'h524, 32'h00, 1'b0, "R4 relocked commit unchanged");

    for (int i = 0; i < 7; i++)
      wr(pads[i], 32'h300 | 32'((i + 1) * 8'h11), 1'b0, "R6 pad write");
    for (int i = 0; i < 7; i++)
      rd(pads[i], 32'((i + 1) * 8'h11), 1'b0, "R6 pad readback");

    for (int i = 0; i < 12; i++)
      rd(12'hFD0 + 12'(i * 4), {24'd0, id_tab[i]}, 1'b0, "R7 id byte");

    rd(12'h430, 32'd0, 1'b1, "R8 R9 unmapped read");
    rd(12'h421, 32'd0, 1'b1, "R8 R9 misaligned read");
    wr(12'h422, 32'h00, 1'b1, "R8 R9 misaligned write");
    rd(12'h420, 32'hAC, 1'b0, "R8 misaligned write ignored");
    wr(12'h434, 32'hFF, 1'b1, "R8 R9 unmapped write");
    wr(12'h510, 32'h0ACCE551, 1'b1, "R8 R9 hole in pad block");
    rd(12'h520, 32'd1, 1'b0, "R8 hole write no unlock");
    wr(12'hFE0, 32'h55, 1'b1, "R8 R9 id write");
    rd(12'hFE0, 32'h61, 1'b0, "R8 id unchanged");
    rd(12'h500, 32'h11, 1'b0, "R9 mapped read no err");

    @(negedge clk);
    check("R10 rdata held when idle", rdata, 32'h11);
    check("R9 err low on idle", {31'd0, err}, 32'd0);
    @(negedge clk);
    check("R1 R4 scoreboard drained", 32'(sb.size()), 32'd0);
    finish_run();
  end
endmodule